// File: doc/BRIEF.md
# DRAM Refresh Address Counter

This block keeps the 8-bit refresh register of a processor core and forms the address used for dynamic memory refresh. Each time an opcode fetch completes, the seven low bits of the register advance by one and wrap within themselves. The top bit changes only when software writes the whole register through the load port.

While the core decodes and executes the fetched instruction, the sequencer raises the refresh-slot input. For that time the block places the interrupt page byte on the upper half of a 16-bit address and the refresh register on the lower half. It also raises a refresh strobe and an address-drive enable. Outside the slot the block drives nothing: the enable is low and the address output reads zero, so the surrounding bus logic can merge it with other sources.

Reset is asynchronous and active low. Its release is synchronised to the clock through two flops, so the register leaves reset on the second rising edge after the reset input goes high.

Top module: `dram_rfsh_addr`

## Requirements
- R1: After reset the refresh register holds 0x00.
- R2: A cycle with `fetch_done_i` high and `load_en_i` low adds one to bits 6:0 of the register at the next rising edge.
- R3: An increment never changes bit 7 of the register.
- R4: Bits 6:0 wrap from 0x7F to 0x00 while bit 7 is kept, so 0xFF becomes 0x80 and 0x7F becomes 0x00.
- R5: A cycle with `load_en_i` high writes all eight bits of `load_val_i` into the register at the next rising edge.
- R6: When `load_en_i` and `fetch_done_i` are high in the same cycle, the loaded value is stored with no increment applied.
- R7: While `refresh_slot_i` is high, `addr_o[15:8]` equals `page_i`, `addr_o[7:0]` equals the register, and `rfsh_o` and `addr_drive_o` are both high. These outputs follow the inputs combinationally within the same cycle.
- R8: While `refresh_slot_i` is low, `rfsh_o` and `addr_drive_o` are low and `addr_o` is 0x0000.
- R9: A cycle with neither `load_en_i` nor `fetch_done_i` high leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_done_i | input | 1 | Pulse marking a completed opcode fetch |
| load_en_i | input | 1 | Write strobe for the refresh register |
| load_val_i | input | 8 | Value written when `load_en_i` is high |
| refresh_slot_i | input | 1 | High during the refresh slot |
| page_i | input | 8 | Interrupt page byte for the upper address half |
| addr_o | output | 16 | Refresh address; zero when not driving |
| addr_drive_o | output | 1 | High when `addr_o` is being driven |
| rfsh_o | output | 1 | Refresh strobe |

## Verification
The register can only be seen on the low address byte during a refresh slot, so the bench holds the slot open and reads the register there. A wrong count, a disturbed bit 7 or a missed wrap shows on `addr_o[7:0]` in the first slot after the rising edge that caused it, which is one cycle after the bad stimulus. Every load value is swept and followed by one increment, and one long run of increments passes through both wrap points, so a fault in any bit of the next-state logic appears within one cycle of that stimulus.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    RF_HOLD = 2'd0,
    RF_INC  = 2'd1,
    RF_LOAD = 2'd2
  } rfsh_op_e;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter
  import rfsh_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             fetch_done_i,
  input  logic             load_en_i,
  input  logic [REG_W-1:0] load_val_i,
  output logic [REG_W-1:0] rfsh_q
);
  localparam int CNT_W = REG_W - 1;

  rfsh_op_e         op;
  logic [REG_W-1:0] rfsh_d;
  logic             rfsh_en;
  logic [CNT_W-1:0] cnt_inc;

  // Load has priority over an increment in the same cycle.
  always_comb begin
    if (load_en_i)         op = RF_LOAD;
    else if (fetch_done_i) op = RF_INC;
    else                   op = RF_HOLD;
  end

  assign cnt_inc = rfsh_q[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    rfsh_d  = rfsh_q;
    rfsh_en = 1'b0;
    unique case (op)
      RF_LOAD: begin
        rfsh_d  = load_val_i;
        rfsh_en = 1'b1;
      end
      RF_INC: begin
        rfsh_d  = {rfsh_q[REG_W-1], cnt_inc};
        rfsh_en = 1'b1;
      end
      default: begin
        rfsh_d  = rfsh_q;
        rfsh_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rfsh_q <= '0;
    else if (rfsh_en) rfsh_q <= rfsh_d;
  end
endmodule

// File: rtl/rfsh_addr_mux.sv
module rfsh_addr_mux #(
  parameter int REG_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic                    refresh_slot_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [REG_W-1:0]        rfsh_q,
  output logic [PAGE_W+REG_W-1:0] addr_o,
  output logic                    addr_drive_o,
  output logic                    rfsh_o
);
  localparam int ADDR_W = PAGE_W + REG_W;

  always_comb begin
    addr_o       = '0;
    addr_drive_o = 1'b0;
    rfsh_o       = 1'b0;
    if (refresh_slot_i) begin
      addr_o       = {page_i, rfsh_q};
      addr_drive_o = 1'b1;
      rfsh_o       = 1'b1;
    end
  end

  logic [ADDR_W-1:0] unused_width_ref;
  assign unused_width_ref = addr_o;
endmodule

// File: rtl/dram_rfsh_addr.sv
module dram_rfsh_addr #(
  parameter int REG_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_done_i,
  input  logic                    load_en_i,
  input  logic [REG_W-1:0]        load_val_i,
  input  logic                    refresh_slot_i,
  input  logic [PAGE_W-1:0]       page_i,
  output logic [PAGE_W+REG_W-1:0] addr_o,
  output logic                    addr_drive_o,
  output logic                    rfsh_o
);
  logic             rst_sync_n;
  logic [REG_W-1:0] rfsh_q;

  rfsh_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfsh_counter #(.REG_W(REG_W)) u_counter (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .fetch_done_i (fetch_done_i),
    .load_en_i    (load_en_i),
    .load_val_i   (load_val_i),
    .rfsh_q       (rfsh_q)
  );

  rfsh_addr_mux #(.REG_W(REG_W), .PAGE_W(PAGE_W)) u_mux (
    .refresh_slot_i (refresh_slot_i),
    .page_i         (page_i),
    .rfsh_q         (rfsh_q),
    .addr_o         (addr_o),
    .addr_drive_o   (addr_drive_o),
    .rfsh_o         (rfsh_o)
  );
endmodule

// File: rtl/dram_rfsh_addr_chk.sv
module dram_rfsh_addr_chk #(
  parameter int REG_W  = 8,
  parameter int PAGE_W = 8
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    fetch_done_i,
  input logic                    load_en_i,
  input logic [REG_W-1:0]        load_val_i,
  input logic                    refresh_slot_i,
  input logic [PAGE_W-1:0]       page_i,
  input logic [REG_W-1:0]        rfsh_q,
  input logic [PAGE_W+REG_W-1:0] addr_o,
  input logic                    addr_drive_o,
  input logic                    rfsh_o
);
  localparam int CNT_W = REG_W - 1;

  AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en_i |=> rfsh_q == $past(load_val_i)); // R5

  AST_LOAD_BEATS_INC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_en_i && fetch_done_i) |=> rfsh_q == $past(load_val_i)); // R6

  AST_LOW_BITS_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_done_i && !load_en_i) |=>
      rfsh_q[CNT_W-1:0] == CNT_W'($past(rfsh_q[CNT_W-1:0]) + 1'b1)); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_done_i && !load_en_i && (&rfsh_q[CNT_W-1:0])) |=>
      rfsh_q[CNT_W-1:0] == '0); // R4

  AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_en_i |=> rfsh_q[REG_W-1] == $past(rfsh_q[REG_W-1])); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en_i && !fetch_done_i) |=> $stable(rfsh_q)); // R9

  AST_SLOT_DRIVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    refresh_slot_i |-> (rfsh_o && addr_drive_o &&
                        addr_o[PAGE_W+REG_W-1:REG_W] == page_i)); // R7

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !refresh_slot_i |-> (!rfsh_o && !addr_drive_o && addr_o == '0)); // R8
endmodule

bind dram_rfsh_addr dram_rfsh_addr_chk #(.REG_W(REG_W), .PAGE_W(PAGE_W)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .fetch_done_i   (fetch_done_i),
  .load_en_i      (load_en_i),
  .load_val_i     (load_val_i),
  .refresh_slot_i (refresh_slot_i),
  .page_i         (page_i),
  .rfsh_q         (rfsh_q),
  .addr_o         (addr_o),
  .addr_drive_o   (addr_drive_o),
  .rfsh_o         (rfsh_o)
);

// File: tb/dram_rfsh_addr_bench.sv
`timescale 1ns/1ps
module dram_rfsh_addr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_done_i = 1'b0;
  logic        load_en_i = 1'b0;
  logic [7:0]  load_val_i = 8'h00;
  logic        refresh_slot_i = 1'b0;
  logic [7:0]  page_i = 8'h00;
  logic [15:0] addr_o;
  logic        addr_drive_o;
  logic        rfsh_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  dram_rfsh_addr u_dram_rfsh_addr (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_done_i   (fetch_done_i),
    .load_en_i      (load_en_i),
    .load_val_i     (load_val_i),
    .refresh_slot_i (refresh_slot_i),
    .page_i         (page_i),
    .addr_o         (addr_o),
    .addr_drive_o   (addr_drive_o),
    .rfsh_o         (rfsh_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock step: inputs change at the falling edge, results sampled there too.
  task automatic step(input logic fd, input logic ld, input logic [7:0] lv);
    fetch_done_i = fd; load_en_i = ld; load_val_i = lv;
    @(posedge clk); @(negedge clk);
    fetch_done_i = 1'b0; load_en_i = 1'b0;
  endtask

  function automatic logic [7:0] inc_model(input logic [7:0] v);
    return {v[7], 7'(v[6:0] + 7'd1)};
  endfunction

  task automatic peek(input string req, input logic [7:0] pg, input logic [7:0] exp);
    refresh_slot_i = 1'b1; page_i = pg; #1;
    check(req, addr_o, {pg, exp});
    check(req, {14'd0, rfsh_o, addr_drive_o}, 16'd3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset value seen through the slot
    peek("R1", 8'h5A, 8'h00);
    // R8: outside the slot nothing is driven
    refresh_slot_i = 1'b0; page_i = 8'hC3; #1;
    check("R8", addr_o, 16'h0000);
    check("R8", {14'd0, rfsh_o, addr_drive_o}, 16'd0);

    // R5, R2, R3, R4: every load value, then one increment
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b1, 8'(v));
      peek("R5", 8'(255 - v), 8'(v));
      step(1'b1, 1'b0, 8'h00);
      peek((v[6:0] == 7'h7F) ? "R4" : "R2_R3", 8'(v), inc_model(8'(v)));
      refresh_slot_i = 1'b0;
    end

    // R9: idle cycles hold, with the slot both open and closed
    step(1'b0, 1'b1, 8'hA7);
    for (int k = 0; k < 4; k++) begin
      refresh_slot_i = k[0];
      step(1'b0, 1'b0, 8'h00);
    end
    peek("R9", 8'h11, 8'hA7);

    // R6: load and fetch together take the load value
    step(1'b1, 1'b1, 8'h3C);
    peek("R6", 8'h22, 8'h3C);
    step(1'b1, 1'b1, 8'hFF);
    peek("R6", 8'h22, 8'hFF);

    // R2, R3, R4: long run of increments through the wrap, bit 7 set and clear
    for (int b = 0; b < 2; b++) begin
      model = b[0] ? 8'h80 : 8'h00;
      step(1'b0, 1'b1, model);
      for (int n = 0; n < 300; n++) begin
        refresh_slot_i = n[0];
        step(1'b1, 1'b0, 8'h00);
        model = inc_model(model);
        peek("R2_R3_R4", 8'(n), model);
      end
    end

    // R7: page byte sweep with a fixed register value
    step(1'b0, 1'b1, 8'h6E);
    for (int p = 0; p < 256; p++) peek("R7", 8'(p), 8'h6E);
    refresh_slot_i = 1'b0; #1;
    check("R8", addr_o, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule